// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block serves a serial frame receiver. It hands the receiver's bytes into host buffers described by a ring of descriptors held in a small local memory. Each descriptor is four 16-bit halfwords: a status/control word, a byte count, and a 32-bit buffer address split into a high and a low half. The engine fetches the descriptor at its current ring position. It opens the descriptor only if the host has marked it as owned by the engine. It then stores each incoming byte at the buffer address plus the running count.

A buffer is closed when the frame ends or when the buffer reaches its fixed capacity. On close, the engine writes the count, then writes the status word with ownership handed back to the host. The status word also carries first/last-of-frame markers and the error flags the receiver reported with the final byte. If the descriptor asks for it, the engine raises a buffer event or a frame event. It then moves to the next descriptor, or back to the ring base when the closed descriptor carries the wrap mark. The ring length is set only by where the host places the wrap mark.

If the descriptor at the current position still belongs to the host, the engine raises a busy level and keeps re-reading that same descriptor until the host releases it. Bytes that arrive while no buffer is open are dropped, and each dropped byte is flagged.

Top module: `rx_bd_ring`

## Requirements
- R1: After reset, no buffer is open and `ring_busy`, `evt_buf` and `evt_frame` are low. The first memory access is a read at `ring_base`.
- R2: A descriptor occupies four consecutive halfword addresses: status at +0, byte count at +1, buffer address bits 31:16 at +2 and bits 15:0 at +3.
- R3: Status bit 15 is the ownership bit (1 = engine may use the buffer). When it reads 0, the engine raises `ring_busy`, keeps `rx_armed` low, and re-reads status at the same address until the bit reads 1. It does so without writing that descriptor.
- R4: While a buffer is open, `rx_armed` is high and each byte with `rx_valid` is written through `buf_we` at buffer address plus the number of bytes already stored. A byte presented while no buffer is open is not stored, and `rx_drop` is high in that cycle.
- R5: When the stored count reaches BUF_BYTES without `rx_last`, the buffer closes with count BUF_BYTES, status bit 11 (last) clear, and error bits zero.
- R6: A byte with `rx_last` closes the buffer: the count written is the number of bytes stored, bit 11 is set, and `rx_err` is recorded in status bits ERR_W-1:0.
- R7: Status bit 10 (first) is set only when the first byte of the buffer is the first byte of a frame, that is, the previously presented byte carried `rx_last` or none was presented since reset.
- R8: On close, the count halfword is written, then the status halfword in the following cycle. The status halfword has bit 15 and bit 14 cleared, and keeps bit 13 (wrap), bit 12 (interrupt) and bits 9:ERR_W as read from the host.
- R9: After a descriptor with bit 13 set is closed, the next status read is at `ring_base`. Otherwise it is at the closed descriptor's address plus 4.
- R10: In the cycle of the status write, `evt_frame` pulses when bit 11 is being set. `evt_buf` pulses when bit 11 is clear and bit 12 was read as 1. Neither pulses otherwise, and the two never pulse together.
- R11: At most one of `mem_re` and `mem_we` is high in a cycle. Read data is taken from `mem_rdata` one cycle after `mem_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ring_base | input | ADDR_W | Halfword address of the first descriptor |
| mem_re | output | 1 | Descriptor memory read strobe |
| mem_we | output | 1 | Descriptor memory write strobe |
| mem_addr | output | ADDR_W | Descriptor memory halfword address |
| mem_wdata | output | 16 | Descriptor memory write data |
| mem_rdata | input | 16 | Descriptor memory read data, valid one cycle after mem_re |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_err | input | ERR_W | Error flags of the frame, valid with rx_last |
| rx_armed | output | 1 | A buffer is open and will store a byte this cycle |
| rx_drop | output | 1 | A presented byte is discarded |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte data |
| ring_busy | output | 1 | Stalled on a host-owned descriptor |
| evt_buf | output | 1 | Buffer-complete event pulse |
| evt_frame | output | 1 | Frame-complete event pulse |

## Verification
The bench builds the engine with BUF_BYTES set to 5, ERR_W at 6 and an 8-bit address. It places a three-descriptor ring at halfword 0x10. The small capacity lets a seven-byte frame spill across two buffers, so a fill close, a continuation buffer without the first marker, and a wrap back to the base all happen within a few dozen cycles. The bench then returns descriptors to the host one at a time. This exercises busy polling at the base and at base plus 4, a dropped byte during the stall, and the interrupt bit both set and clear on fill and frame closes.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int HW      = 16;
   // status word bit positions
   localparam int BIT_E   = 15;
   localparam int BIT_RSV = 14;
   localparam int BIT_W   = 13;
   localparam int BIT_I   = 12;
   localparam int BIT_L   = 11;
   localparam int BIT_F   = 10;
   localparam int LOW_W   = 10;   // bits 9:0 hold preserved + error bits
   localparam int LOW_TOP = LOW_W - 1;
   // halfword offsets inside a descriptor
   localparam int OFS_STAT = 0;
   localparam int OFS_LEN  = 1;
   localparam int OFS_PHI  = 2;
   localparam int OFS_PLO  = 3;
   localparam int BD_SPAN  = 4;

   typedef enum logic [2:0] {
      ST_FETCH, ST_CHECK, ST_PTRH, ST_PTRL, ST_ARM, ST_OPEN, ST_WLEN, ST_WSTAT
   } ring_state_t;
endpackage

// File: rtl/rxr_seq.sv
module rxr_seq
   import rxr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int ERR_W  = 6
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ADDR_W-1:0]    ring_base,
   input  logic [HW-1:0]        mem_rdata,
   input  logic                 fill_done,
   input  logic [HW-1:0]        len_val,
   input  logic                 l_bit,
   input  logic                 f_bit,
   input  logic [ERR_W-1:0]     err_val,
   output ring_state_t          state,
   output logic                 mem_re,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [HW-1:0]        mem_wdata,
   output logic [2*HW-1:0]      ptr,
   output logic                 ring_busy,
   output logic                 i_bit
);
   localparam int KEEP_W = LOW_W - ERR_W;

   ring_state_t       state_q;
   logic [ADDR_W-1:0] cur_q;
   logic [HW-1:0]     ptr_hi_q, ptr_lo_q;
   logic              w_q, i_q, busy_q;
   logic [LOW_W-1:0]  stat_low;
   logic              owned;

   assign owned = mem_rdata[BIT_E];

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_FETCH;
         cur_q    <= ring_base;
         ptr_hi_q <= '0;
         ptr_lo_q <= '0;
         w_q      <= 1'b0;
         i_q      <= 1'b0;
         busy_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_FETCH: state_q <= ST_CHECK;
            ST_CHECK: begin
               if (owned) begin
                  busy_q  <= 1'b0;
                  w_q     <= mem_rdata[BIT_W];
                  i_q     <= mem_rdata[BIT_I];
                  state_q <= ST_PTRH;
               end else begin
                  busy_q  <= 1'b1;
                  state_q <= ST_FETCH;
               end
            end
            ST_PTRH: state_q <= ST_PTRL;
            ST_PTRL: begin
               ptr_hi_q <= mem_rdata;
               state_q  <= ST_ARM;
            end
            ST_ARM: begin
               ptr_lo_q <= mem_rdata;
               state_q  <= ST_OPEN;
            end
            ST_OPEN: if (fill_done) state_q <= ST_WLEN;
            ST_WLEN: state_q <= ST_WSTAT;
            ST_WSTAT: begin
               cur_q   <= w_q ? ring_base : cur_q + ADDR_W'(BD_SPAN);
               state_q <= ST_FETCH;
            end
            default: state_q <= ST_FETCH;
         endcase
      end
   end

   // preserved host bits between the flags and the error field
   generate
      if (KEEP_W > 0) begin : g_keep
         logic [KEEP_W-1:0] keep_q;
         always_ff @(posedge clk) begin
            if (rst)
               keep_q <= '0;
            else if (state_q == ST_CHECK && owned)
               keep_q <= mem_rdata[LOW_TOP -: KEEP_W];
         end
         assign stat_low = {keep_q, err_val};
      end else begin : g_nokeep
         assign stat_low = err_val;
      end
   endgenerate

   always_comb begin
      mem_re    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q;
      mem_wdata = '0;
      case (state_q)
         ST_FETCH: begin
            mem_re   = 1'b1;
            mem_addr = cur_q + ADDR_W'(OFS_STAT);
         end
         ST_PTRH: begin
            mem_re   = 1'b1;
            mem_addr = cur_q + ADDR_W'(OFS_PHI);
         end
         ST_PTRL: begin
            mem_re   = 1'b1;
            mem_addr = cur_q + ADDR_W'(OFS_PLO);
         end
         ST_WLEN: begin
            mem_we    = 1'b1;
            mem_addr  = cur_q + ADDR_W'(OFS_LEN);
            mem_wdata = len_val;
         end
         ST_WSTAT: begin
            mem_we    = 1'b1;
            mem_addr  = cur_q + ADDR_W'(OFS_STAT);
            mem_wdata = {1'b0, 1'b0, w_q, i_q, l_bit, f_bit, stat_low};
         end
         default: ;
      endcase
   end

   assign state     = state_q;
   assign ptr       = {ptr_hi_q, ptr_lo_q};
   assign ring_busy = busy_q;
   assign i_bit     = i_q;
endmodule

// File: rtl/rxr_fill.sv
module rxr_fill
   import rxr_pkg::*;
#(
   parameter int BUF_BYTES = 64,
   parameter int ERR_W     = 6
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              arm,
   input  logic              open,
   input  logic [2*HW-1:0]   ptr,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_last,
   input  logic [ERR_W-1:0]  rx_err,
   output logic              done,
   output logic [HW-1:0]     len_val,
   output logic              f_bit,
   output logic              l_bit,
   output logic [ERR_W-1:0]  err_val,
   output logic              buf_we,
   output logic [2*HW-1:0]   buf_addr,
   output logic [7:0]        buf_data,
   output logic              rx_drop
);
   localparam int CNT_W = $clog2(BUF_BYTES + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_BYTES);

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             mid_q, f_q, l_q, take;
   logic [ERR_W-1:0] err_q;

   assign take    = open & rx_valid;
   assign cnt_nxt = cnt_q + 1'b1;
   assign done    = take & (rx_last | (cnt_nxt == CNT_FULL));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         mid_q <= 1'b0;
         f_q   <= 1'b0;
         l_q   <= 1'b0;
         err_q <= '0;
      end else begin
         if (arm)
            cnt_q <= '0;
         else if (take)
            cnt_q <= cnt_nxt;
         if (take && cnt_q == '0)
            f_q <= ~mid_q;
         if (done) begin
            l_q   <= rx_last;
            err_q <= rx_last ? rx_err : '0;
         end
         if (rx_valid)
            mid_q <= ~rx_last;
      end
   end

   assign len_val  = HW'(cnt_q);
   assign f_bit    = f_q;
   assign l_bit    = l_q;
   assign err_val  = err_q;
   assign buf_we   = take;
   assign buf_addr = ptr + (2*HW)'(cnt_q);
   assign buf_data = rx_byte;
   assign rx_drop  = rx_valid & ~open;
endmodule

// File: rtl/rxr_event.sv
module rxr_event (
   input  logic wstat,
   input  logic l_bit,
   input  logic i_bit,
   output logic evt_buf,
   output logic evt_frame
);
   assign evt_frame = wstat & l_bit;
   assign evt_buf   = wstat & ~l_bit & i_bit;
endmodule

// File: rtl/rx_bd_ring.sv
module rx_bd_ring
   import rxr_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BUF_BYTES = 64,
   parameter int ERR_W     = 6
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] ring_base,
   output logic              mem_re,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_last,
   input  logic [ERR_W-1:0]  rx_err,
   output logic              rx_armed,
   output logic              rx_drop,
   output logic              buf_we,
   output logic [31:0]       buf_addr,
   output logic [7:0]        buf_data,
   output logic              ring_busy,
   output logic              evt_buf,
   output logic              evt_frame
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("rx_bd_ring: ADDR_W must be at least 3");
      end
      if (ERR_W < 1 || ERR_W > LOW_W) begin : g_bad_err
         $error("rx_bd_ring: ERR_W must lie in 1..10");
      end
      if (BUF_BYTES < 1 || BUF_BYTES > 16383) begin : g_bad_buf
         $error("rx_bd_ring: BUF_BYTES must lie in 1..16383");
      end
   endgenerate

   ring_state_t      state;
   logic             fill_done, l_bit, f_bit, i_bit;
   logic [HW-1:0]    len_val;
   logic [ERR_W-1:0] err_val;
   logic [31:0]      ptr;

   rxr_seq #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .ring_base (ring_base),
      .mem_rdata (mem_rdata),
      .fill_done (fill_done),
      .len_val   (len_val),
      .l_bit     (l_bit),
      .f_bit     (f_bit),
      .err_val   (err_val),
      .state     (state),
      .mem_re    (mem_re),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .ptr       (ptr),
      .ring_busy (ring_busy),
      .i_bit     (i_bit)
   );

   rxr_fill #(.BUF_BYTES(BUF_BYTES), .ERR_W(ERR_W)) u_fill (
      .clk      (clk),
      .rst      (rst),
      .arm      (state == ST_ARM),
      .open     (state == ST_OPEN),
      .ptr      (ptr),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .rx_last  (rx_last),
      .rx_err   (rx_err),
      .done     (fill_done),
      .len_val  (len_val),
      .f_bit    (f_bit),
      .l_bit    (l_bit),
      .err_val  (err_val),
      .buf_we   (buf_we),
      .buf_addr (buf_addr),
      .buf_data (buf_data),
      .rx_drop  (rx_drop)
   );

   rxr_event u_evt (
      .wstat     (state == ST_WSTAT),
      .l_bit     (l_bit),
      .i_bit     (i_bit),
      .evt_buf   (evt_buf),
      .evt_frame (evt_frame)
   );

   assign rx_armed = (state == ST_OPEN);
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk (
   input logic        clk,
   input logic        rst,
   input logic        mem_re,
   input logic        mem_we,
   input logic [15:0] mem_wdata,
   input logic [15:0] mem_rdata,
   input logic        rx_valid,
   input logic        rx_armed,
   input logic        rx_drop,
   input logic        buf_we,
   input logic [31:0] buf_addr,
   input logic        ring_busy,
   input logic        evt_buf,
   input logic        evt_frame
);
   // R11
   excl_access_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_re && mem_we));

   // R4
   store_when_open_chk: assert property (@(posedge clk) disable iff (rst)
      buf_we |-> (rx_armed && rx_valid));

   // R4
   drop_not_stored_chk: assert property (@(posedge clk) disable iff (rst)
      rx_drop |-> !buf_we);

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (rst)
      (buf_we && $past(buf_we) && rx_armed && $past(rx_armed))
         |-> buf_addr == $past(buf_addr) + 32'd1);

   // R10
   evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({evt_buf, evt_frame}));

   // R10
   frame_evt_chk: assert property (@(posedge clk) disable iff (rst)
      evt_frame |-> (mem_we && mem_wdata[11]));

   // R8
   owner_return_chk: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (!mem_wdata[15] && !mem_wdata[14]));

   // R3
   busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ring_busy) |-> !$past(mem_rdata[15]));

   // R3
   busy_closed_chk: assert property (@(posedge clk) disable iff (rst)
      ring_busy |-> !rx_armed);
endmodule

bind rx_bd_ring rxr_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .mem_re    (mem_re),
   .mem_we    (mem_we),
   .mem_wdata (mem_wdata),
   .mem_rdata (mem_rdata),
   .rx_valid  (rx_valid),
   .rx_armed  (rx_armed),
   .rx_drop   (rx_drop),
   .buf_we    (buf_we),
   .buf_addr  (buf_addr),
   .ring_busy (ring_busy),
   .evt_buf   (evt_buf),
   .evt_frame (evt_frame)
);

// File: tb/tb_rx_bd_ring.sv
`timescale 1ns/1ps
module tb_rx_bd_ring;
   localparam int BUF = 5;
   localparam logic [7:0] BASE = 8'h10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mem_re, mem_we;
   logic [7:0]  mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_last = 1'b0;
   logic [5:0]  rx_err = '0;
   logic        rx_armed, rx_drop, buf_we, ring_busy, evt_buf, evt_frame;
   logic [31:0] buf_addr;
   logic [7:0]  buf_data;

   int checks = 0;
   int fails  = 0;
   int n_frame = 0;
   int n_buf   = 0;

   logic [15:0] mem [0:255];
   logic [7:0]  bufmem [logic [31:0]];

   always #4 clk = ~clk;

   rx_bd_ring #(.ADDR_W(8), .BUF_BYTES(BUF), .ERR_W(6)) dut (
      .clk(clk), .rst(rst), .ring_base(BASE),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last), .rx_err(rx_err),
      .rx_armed(rx_armed), .rx_drop(rx_drop),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .ring_busy(ring_busy), .evt_buf(evt_buf), .evt_frame(evt_frame)
   );

   // descriptor memory with one-cycle read latency, host may poke it
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
      if (buf_we) bufmem[buf_addr] = buf_data;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference: phase number, descriptor cursor, captured fields
   int          m_step;
   int          m_cnt;
   logic [7:0]  m_cur;
   logic [15:0] m_rd, m_phi, m_plo;
   logic        m_w, m_i, m_l, m_f, m_mid, m_busy;
   logic [3:0]  m_keep;
   logic [5:0]  m_err;

   always @(posedge clk) begin
      if (rst) begin
         m_step = 0; m_cnt = 0; m_cur = BASE; m_rd = '0; m_phi = '0; m_plo = '0;
         m_w = 0; m_i = 0; m_l = 0; m_f = 0; m_mid = 0; m_busy = 0;
         m_keep = '0; m_err = '0;
      end else begin
         case (m_step)
            0: begin m_rd = mem[m_cur]; m_step = 1; end
            1: if (m_rd[15]) begin
                  m_busy = 0; m_w = m_rd[13]; m_i = m_rd[12]; m_keep = m_rd[9:6]; m_step = 2;
               end else begin
                  m_busy = 1; m_step = 0;
               end
            2: begin m_rd = mem[m_cur + 8'd2]; m_step = 3; end
            3: begin m_phi = m_rd; m_rd = mem[m_cur + 8'd3]; m_step = 4; end
            4: begin m_plo = m_rd; m_cnt = 0; m_step = 5; end
            5: if (rx_valid) begin
                  if (m_cnt == 0) m_f = !m_mid;
                  m_cnt++;
                  if (rx_last || m_cnt == BUF) begin
                     m_l = rx_last; m_err = rx_last ? rx_err : 6'd0; m_step = 6;
                  end
               end
            6: m_step = 7;
            default: begin m_cur = m_w ? BASE : m_cur + 8'd4; m_step = 0; end
         endcase
         if (rx_valid) m_mid = !rx_last;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         logic        e_re, e_we;
         logic [7:0]  e_addr;
         logic [15:0] e_wd;
         e_re = (m_step == 0 || m_step == 2 || m_step == 3);
         e_we = (m_step == 6 || m_step == 7);
         e_addr = (m_step == 2) ? m_cur + 8'd2 : (m_step == 3) ? m_cur + 8'd3 :
                  (m_step == 6) ? m_cur + 8'd1 : m_cur;
         e_wd = (m_step == 6) ? 16'(m_cnt) :
                {2'b00, m_w, m_i, m_l, m_f, m_keep, m_err};
         chk("R11 mem_re", mem_re, e_re);
         chk("R11 mem_we", mem_we, e_we);
         if (e_re || e_we) chk("R9 mem_addr", mem_addr, e_addr);
         if (e_we) chk("R8 mem_wdata", mem_wdata, e_wd);
         chk("R4 rx_armed", rx_armed, m_step == 5);
         chk("R4 rx_drop", rx_drop, rx_valid && m_step != 5);
         chk("R4 buf_we", buf_we, rx_valid && m_step == 5);
         if (buf_we) begin
            chk("R4 buf_addr", buf_addr, {m_phi, m_plo} + 32'(m_cnt));
            chk("R4 buf_data", buf_data, rx_byte);
         end
         chk("R3 ring_busy", ring_busy, m_busy);
         chk("R10 evt_frame", evt_frame, m_step == 7 && m_l);
         chk("R10 evt_buf", evt_buf, m_step == 7 && !m_l && m_i);
         if (evt_frame) n_frame++;
         if (evt_buf) n_buf++;
      end
   end

   task automatic send(input logic [7:0] b, input logic last, input logic [5:0] e);
      do begin @(posedge clk); #1; end while (!rx_armed);
      rx_valid = 1'b1; rx_byte = b; rx_last = last; rx_err = e;
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_last = 1'b0; rx_err = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int a = 0; a < 256; a++) mem[a] = '0;
      mem[8'h10] = 16'h9000; mem[8'h12] = 16'h1000; mem[8'h13] = 16'h0000;
      mem[8'h14] = 16'h8000; mem[8'h16] = 16'h2000; mem[8'h17] = 16'h0040;
      mem[8'h18] = 16'hB3C0; mem[8'h1A] = 16'h3000; mem[8'h1B] = 16'h0100;
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk("R1 first read", mem_re, 1'b1);
      chk("R1 read at base", mem_addr, BASE);
      chk("R1 not armed", rx_armed, 1'b0);
      chk("R1 busy low", ring_busy, 1'b0);
      chk("R1 events low", {evt_buf, evt_frame}, 2'b00);

      // frame A: three bytes, ends with error flags
      send(8'hA0, 0, 0); send(8'hA1, 0, 0); send(8'hA2, 1, 6'h05);
      idle(8);
      chk("R6 D0 length", mem[8'h11], 16'd3);
      chk("R6 R7 R8 D0 status", mem[8'h10], 16'h1C05);
      chk("R2 first byte at pointer", bufmem[32'h1000_0000], 8'hA0);

      // frame B: seven bytes spill over two buffers, then wrap
      for (int k = 0; k < 7; k++) send(8'hB0 + 8'(k), k == 6, 6'h0);
      idle(20);
      chk("R5 D1 length", mem[8'h15], 16'd5);
      chk("R5 R10 D1 status", mem[8'h14], 16'h0400);
      chk("R2 pointer halves", bufmem[32'h2000_0044], 8'hB4);
      chk("R7 R8 D2 status", mem[8'h18], 16'h3BC0);
      chk("R6 D2 length", mem[8'h19], 16'd2);
      chk("R10 frame events", n_frame, 2);
      chk("R10 no buffer events", n_buf, 0);
      chk("R9 R3 busy after wrap", ring_busy, 1'b1);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (mem_re) chk("R3 R9 poll at base", mem_addr, BASE);
      end
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_byte = 8'hEE; rx_last = 1'b1;
      #2 chk("R4 drop flagged", rx_drop, 1'b1);
      chk("R4 drop not stored", buf_we, 1'b0);
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_last = 1'b0;
      idle(4);
      chk("R3 D0 untouched", mem[8'h11], 16'd3);

      // release D0, frame C fills it with interrupt set
      mem[8'h10] = 16'h9000; mem[8'h11] = 16'h0000;
      for (int k = 0; k < 5; k++) send(8'hC0 + 8'(k), 0, 6'h0);
      idle(20);
      chk("R5 D0 fill length", mem[8'h11], 16'd5);
      chk("R5 R7 D0 fill status", mem[8'h10], 16'h1400);
      chk("R10 buffer event", n_buf, 1);
      chk("R4 last stored byte", bufmem[32'h1000_0004], 8'hC4);
      chk("R3 busy on D1", ring_busy, 1'b1);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (mem_re) chk("R9 poll at base+4", mem_addr, BASE + 8'd4);
      end

      // release D1, frame continues with interrupt clear
      @(posedge clk); #1;
      mem[8'h14] = 16'h8000; mem[8'h15] = 16'h0000;
      send(8'hD0, 0, 0); send(8'hD1, 1, 6'h2A);
      idle(20);
      chk("R6 D1 end length", mem[8'h15], 16'd2);
      chk("R7 R6 D1 end status", mem[8'h14], 16'h082A);
      chk("R10 frame event with I clear", n_frame, 3);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (mem_re) chk("R9 poll at base+8", mem_addr, BASE + 8'd8);
      end
      idle(2);
      finish_run();
   end
endmodule